// File: doc/BRIEF.md
# Three-Phase Half-Bridge Gate-Drive Controller

This block is the synchronous control core of a three-phase half-bridge gate driver. Each of the three legs takes two active-low switch commands, one for the upper switch and one for the lower. The block turns them into active-high gate enables. It inserts a dead interval whenever a leg hands conduction from one switch to the other. It never lets both switches of a leg conduct together.

A shared fault manager watches a digitized overcurrent trip and a digitized low-side undervoltage flag. Either one forces all six gate enables off in the same cycle and pulls the active-low fault output low. A mode pin chooses how the fault clears. In timed mode it clears after a parameterised run of fault-free cycles. In latched mode it clears only when a clear request arrives while no fault source is present. Dropping the enable also shuts all gates, but it does not report a fault. Every restart after a shutdown passes through a fresh dead interval.

All pins are plain control levels sampled on the rising clock edge. There is no data stream, so no valid/ready handshake applies.

Top module: `gate_drive_ctrl`

## Requirements
- R1: With no shutdown active and the dead interval over, `gate_hi[i]` is 1 exactly when `cmd_hi_n[i]` is 0 and `cmd_lo_n[i]` is 1. `gate_lo[i]` behaves the same way with the roles of the two commands swapped. A gate drops in the same cycle its command is withdrawn.
- R2: `gate_hi[i]` and `gate_lo[i]` are never both 1. If both commands of a leg are 0, both gates of that leg are 0.
- R3: Once a leg's gates are both off, neither gate of that leg turns on until DEAD_CYC+1 rising edges have passed. The leg's dead counter starts at the edge where the leg goes idle and saturates at DEAD_CYC. At the next edge with a valid command, the gate turns on.
- R4: A 1 on `trip` forces all six gates to 0 in the same cycle. `fault_n` reads 0 from the next rising edge.
- R5: A 1 on `uv_lo` behaves exactly like `trip`: all gates go off at once and `fault_n` goes to 0.
- R6: With `latch_mode`=0, `fault_n` returns to 1 after CLR_CYC consecutive edges at which the fault is held and both `trip` and `uv_lo` are 0. Any new trip or undervoltage restarts this count.
- R7: With `latch_mode`=1, the fault stays set and `fault_n` stays 0 until an edge at which `clr_req`=1 and both `trip` and `uv_lo` are 0. A `clr_req` that arrives while `trip` is 1 has no effect.
- R8: `enable`=0 forces all gates to 0 in the same cycle and leaves `fault_n` at 1.
- R9: After a fault clears or `enable` returns to 1, each leg starts from an idle state with its dead counter at zero, so R3's full interval applies before any gate turns on.
- R10: While `rst` is 1 at a rising edge, all legs become idle with counters cleared and the fault clears. After that edge `fault_n` is 1 and all gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi_n | input | PHASES | Upper-switch commands, active low, one bit per leg |
| cmd_lo_n | input | PHASES | Lower-switch commands, active low, one bit per leg |
| enable | input | 1 | 1 allows switching; 0 shuts all gates without a fault |
| trip | input | 1 | Digitized overcurrent trip, active high |
| uv_lo | input | 1 | Digitized low-side undervoltage, active high |
| latch_mode | input | 1 | 0 selects timed clear; 1 selects clear on request |
| clr_req | input | 1 | Fault clear request, used in latched mode |
| gate_hi | output | PHASES | Upper gate enables, active high |
| gate_lo | output | PHASES | Lower gate enables, active high |
| fault_n | output | 1 | Fault indication, 0 while a fault is held |

## Verification
A leg state stuck in a conducting side would show up at once as a gate that stays on after its command changes, or as both gates of a leg on together. A dead counter off by one moves the turn-on edge by one cycle, and that edge is compared every cycle against an independently timed model. A fault counter that fails to restart, or that clears in the wrong mode, shows up as `fault_n` rising early or late. Because the outputs are compared on every clock, any such error is seen within a single cycle of the wrong edge.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
  typedef enum logic [1:0] {
    SIDE_OFF = 2'd0,
    SIDE_HI  = 2'd1,
    SIDE_LO  = 2'd2
  } side_e;
endpackage

// File: rtl/gdc_leg.sv
module gdc_leg
  import gdc_pkg::*;
#(
  parameter int DEAD_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic cmd_h_n,
  input  logic cmd_l_n,
  output logic gate_h,
  output logic gate_l
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_MAX = DW'(DEAD_CYC);

  side_e         cur_q;
  side_e         req;
  logic [DW-1:0] dcnt_q;

  always_comb begin
    if (!cmd_h_n && cmd_l_n)      req = SIDE_HI;
    else if (!cmd_l_n && cmd_h_n) req = SIDE_LO;
    else                          req = SIDE_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      cur_q  <= SIDE_OFF;
      dcnt_q <= '0;
    end else if (cur_q == SIDE_OFF) begin
      if (dcnt_q == DEAD_MAX && req != SIDE_OFF) begin
        cur_q  <= req;
        dcnt_q <= '0;
      end else if (dcnt_q != DEAD_MAX) begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end else if (req != cur_q) begin
      cur_q  <= SIDE_OFF;
      dcnt_q <= '0;
    end
  end

  assign gate_h = (cur_q == SIDE_HI) && (req == SIDE_HI) && !kill;
  assign gate_l = (cur_q == SIDE_LO) && (req == SIDE_LO) && !kill;

  // R3
  dead_done_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q != SIDE_OFF && $past(cur_q) == SIDE_OFF) |-> $past(dcnt_q) == DEAD_MAX);

  // R9
  kill_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(kill) |-> (cur_q == SIDE_OFF && dcnt_q == '0));
endmodule

// File: rtl/gdc_fault.sv
module gdc_fault #(
  parameter int CLR_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic uv_lo,
  input  logic latch_mode,
  input  logic clr_req,
  output logic faulted
);
  localparam int CW = $clog2(CLR_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLR_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          flt_q;
  logic          src;

  assign src = trip | uv_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (src) begin
      flt_q <= 1'b1;
      cnt_q <= '0;
    end else if (flt_q) begin
      if (latch_mode) begin
        cnt_q <= '0;
        if (clr_req) flt_q <= 1'b0;
      end else if (cnt_q == CNT_LAST) begin
        flt_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign faulted = flt_q;

  // R4
  trip_sets_chk: assert property (@(posedge clk) disable iff (rst)
    $past(src) |-> flt_q);

  // R7
  latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(flt_q) && $past(latch_mode)) |-> $past(clr_req));
endmodule

// File: rtl/gate_drive_ctrl.sv
module gate_drive_ctrl #(
  parameter int PHASES   = 3,
  parameter int DEAD_CYC = 30,
  parameter int CLR_CYC  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] cmd_hi_n,
  input  logic [PHASES-1:0] cmd_lo_n,
  input  logic              enable,
  input  logic              trip,
  input  logic              uv_lo,
  input  logic              latch_mode,
  input  logic              clr_req,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo,
  output logic              fault_n
);
  logic faulted;
  logic kill;

  gdc_fault #(.CLR_CYC(CLR_CYC)) u_fault (
    .clk(clk), .rst(rst), .trip(trip), .uv_lo(uv_lo),
    .latch_mode(latch_mode), .clr_req(clr_req), .faulted(faulted)
  );

  assign kill    = trip | uv_lo | faulted | ~enable;
  assign fault_n = ~faulted;

  for (genvar g = 0; g < PHASES; g++) begin : g_leg
    gdc_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst(rst), .kill(kill),
      .cmd_h_n(cmd_hi_n[g]), .cmd_l_n(cmd_lo_n[g]),
      .gate_h(gate_hi[g]), .gate_l(gate_lo[g])
    );

    // R2
    no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi[g] && gate_lo[g]));
  end

  // R8
  enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (gate_hi == '0 && gate_lo == '0));

  // R5
  uv_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $past(uv_lo) |-> !fault_n);
endmodule

// File: tb/test_gate_drive_ctrl.sv
`timescale 1ns/1ps
module test_gate_drive_ctrl;
  localparam int NP   = 3;
  localparam int DEAD = 30;
  localparam int CLR  = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] cmd_hi_n = '1;
  logic [NP-1:0] cmd_lo_n = '1;
  logic enable = 1'b1, trip = 1'b0, uv_lo = 1'b0, latch_mode = 1'b0, clr_req = 1'b0;
  logic [NP-1:0] gate_hi, gate_lo;
  logic fault_n;

  int checks = 0, errors = 0;
  string tag = "R10";
  bit started = 1'b0;
  bit finished = 1'b0;

  int m_side [NP];
  int m_cnt  [NP];
  bit m_flt = 1'b0;
  int m_fcnt = 0;

  always #4 clk = ~clk;

  gate_drive_ctrl #(.PHASES(NP), .DEAD_CYC(DEAD), .CLR_CYC(CLR)) i_gate_drive_ctrl (
    .clk(clk), .rst(rst), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
    .enable(enable), .trip(trip), .uv_lo(uv_lo), .latch_mode(latch_mode),
    .clr_req(clr_req), .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
  );

  function automatic int want(int i);
    if (!cmd_hi_n[i] && cmd_lo_n[i]) return 1;
    if (!cmd_lo_n[i] && cmd_hi_n[i]) return 2;
    return 0;
  endfunction

  task automatic check(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit off_all;
    off_all = trip || uv_lo || m_flt || !enable;
    for (int i = 0; i < NP; i++) begin
      int w;
      w = want(i);
      if (rst || off_all) begin
        m_side[i] = 0; m_cnt[i] = 0;
      end else if (m_side[i] == 0) begin
        if (m_cnt[i] == DEAD && w != 0) begin
          m_side[i] = w; m_cnt[i] = 0;
        end else if (m_cnt[i] < DEAD) m_cnt[i]++;
      end else if (w != m_side[i]) begin
        m_side[i] = 0; m_cnt[i] = 0;
      end
    end
    if (rst) begin
      m_flt = 1'b0; m_fcnt = 0;
    end else if (trip || uv_lo) begin
      m_flt = 1'b1; m_fcnt = 0;
    end else if (m_flt) begin
      if (latch_mode) begin
        m_fcnt = 0;
        if (clr_req) m_flt = 1'b0;
      end else if (m_fcnt == CLR - 1) begin
        m_flt = 1'b0; m_fcnt = 0;
      end else m_fcnt++;
    end
    started = 1'b1;
    #2;
    if (!finished) begin
      bit off_now;
      off_now = trip || uv_lo || m_flt || !enable;
      for (int i = 0; i < NP; i++) begin
        int eh, el;
        eh = (m_side[i] == 1 && want(i) == 1 && !off_now) ? 1 : 0;
        el = (m_side[i] == 2 && want(i) == 2 && !off_now) ? 1 : 0;
        check(gate_hi[i] === 1'(eh), tag, $sformatf("gate_hi[%0d]", i), int'(gate_hi[i]), eh);
        check(gate_lo[i] === 1'(el), tag, $sformatf("gate_lo[%0d]", i), int'(gate_lo[i]), el);
      end
      check(fault_n === !m_flt, tag, "fault_n", int'(fault_n), int'(!m_flt));
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin m_side[i] = 0; m_cnt[i] = 0; end
    run(3);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle state after reset
    check(fault_n === 1'b1 && gate_hi === '0 && gate_lo === '0, "R10", "reset outputs",
          int'({gate_hi, gate_lo}), 0);
    tag = "R1";  cmd_hi_n = 3'b010; cmd_lo_n = 3'b101; run(50);
    tag = "R3";  cmd_hi_n = 3'b101; cmd_lo_n = 3'b010; run(50);
    cmd_hi_n[2] = 1'b1; cmd_lo_n[2] = 1'b0; run(10);
    cmd_hi_n[2] = 1'b0; cmd_lo_n[2] = 1'b1; run(50);
    tag = "R2";  cmd_hi_n[1] = 1'b0; cmd_lo_n[1] = 1'b0; run(20);
    // R2: both commands active gives no gate on that leg
    check(gate_hi[1] === 1'b0 && gate_lo[1] === 1'b0, "R2", "leg1 both cmds",
          int'({gate_hi[1], gate_lo[1]}), 0);
    cmd_hi_n[1] = 1'b1; run(50);
    tag = "R4";  trip = 1'b1; run(1); trip = 1'b0; run(20);
    tag = "R6";  run(30); trip = 1'b1; run(1); trip = 1'b0; run(120);
    tag = "R9";  run(40);
    tag = "R5";  uv_lo = 1'b1; run(5); uv_lo = 1'b0; run(150);
    tag = "R7";  latch_mode = 1'b1; trip = 1'b1; run(2); trip = 1'b0; run(150);
    // R7: latched fault persists
    check(fault_n === 1'b0, "R7", "latched fault_n", int'(fault_n), 0);
    trip = 1'b1; clr_req = 1'b1; run(1); clr_req = 1'b0; trip = 1'b0; run(5);
    clr_req = 1'b1; run(1); clr_req = 1'b0; run(60);
    latch_mode = 1'b0;
    tag = "R8";  enable = 1'b0; run(20);
    // R8: enable low raises no fault
    check(fault_n === 1'b1, "R8", "fault_n with enable low", int'(fault_n), 1);
    tag = "R9";  enable = 1'b1; run(60);
    tag = "R10"; rst = 1'b1; run(2); rst = 1'b0; run(40);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule